// File: doc/BRIEF.md
# Configuration ID Autoload Sequencer

This block fills in the identification fields of a PCI-style configuration header from an external configuration memory. As soon as reset is released it fetches three consecutive 16-bit words, one at a time, through a word-read port. The port has a registered address, a one-cycle read strobe, and a completion pulse that carries the data. No host is involved in the fetch.

The first word fetched is a control word. Its two top bits form a signature. Only the value 01b marks the memory as usable, and any other value marks it as absent or blank. The next lower bit decides whether the identification fields are loaded. The second word holds the subsystem identifier and the third holds the subsystem vendor identifier. When loading is permitted, the low three bits of the revision identifier come from bits 10:8 of the control word. The upper five bits of the revision identifier are a fixed build parameter. When loading is not permitted, both subsystem fields stay at zero and the revision keeps its parameterised default.

While the sequence runs, the block holds a retry request towards the configuration-access logic, which must answer every access with Retry. A timeout ends a stalled fetch with defaults, so the header can never stay in Retry forever.

Top module: `idAutoload`

## Requirements
- R1: After reset is released, the block issues exactly three read strobes, at addresses BASE_ADDR, BASE_ADDR+1 and BASE_ADDR+2 (default 0xA, 0xB, 0xC) in that order. Each strobe is high for a single cycle and the address is valid while the strobe is high.
- R2: No new strobe is issued while a read is still waiting for its completion pulse.
- R3: Loading is permitted only when control-word bits 15:14 equal 01b and bit 13 equals 1. Then subsysId takes the second word and subsysVendorId takes the third word.
- R4: When loading is permitted, revisionId becomes {REV_UPPER, control bits 10:8}. Otherwise it stays at REV_DEFAULT.
- R5: For any other signature value, or with bit 13 at 0, the second and third words are still fetched, but both subsystem fields stay 0x0000.
- R6: While the sequence is running, the three ID outputs hold their defaults. The fields change only when the sequence completes.
- R7: From reset until completion, cfgRetry is 1 and loadDone is 0. loadDone rises in the cycle after the cycle in which the third completion pulse is accepted, and cfgRetry falls in that same cycle.
- R8: After completion, loadDone and all ID outputs stay constant until the next reset, and completion pulses that arrive later are ignored.
- R9: If TIMEOUT_CYC waiting cycles pass without a completion pulse, the sequence ends with default IDs and loadDone set. A pulse that arrives in exactly the TIMEOUT_CYC-th waiting cycle is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eeReq | output | 1 | One-cycle read strobe to the memory reader |
| eeAddr | output | ADDR_W | Registered word address of the current read |
| eeDone | input | 1 | Completion pulse; eeData is valid with it |
| eeData | input | 16 | Word returned by the memory reader |
| subsysId | output | 16 | Subsystem identifier field |
| subsysVendorId | output | 16 | Subsystem vendor identifier field |
| revisionId | output | 8 | Revision identifier field |
| loadDone | output | 1 | Autoload finished (sticky until reset) |
| cfgRetry | output | 1 | Configuration accesses must be answered with Retry |

## Verification
Two functions can fall in the same cycle: acceptance of a completion pulse and expiry of the wait timeout. These cycles meet when the reader's latency equals TIMEOUT_CYC. The bench provokes this by answering every read after exactly TIMEOUT_CYC waiting cycles, and it expects a full load, because the pulse has priority over expiry. It then delays a single word by one more cycle, for each word in turn, and expects defaults, a set loadDone, and no effect from the late pulse.

// File: rtl/idload_pkg.sv
package idload_pkg;

  localparam int WORD_W    = 16;
  localparam int NUM_WORDS = 3;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  localparam logic [1:0] SIG_GOOD  = 2'b01;
  localparam int         SIG_HI    = 15;
  localparam int         SIG_LO    = 14;
  localparam int         LOAD_BIT  = 13;
  localparam int         REVF_HI   = 10;
  localparam int         REVF_LO   = 8;

  typedef enum logic [1:0] {
    ST_START,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } loadState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic capCtrl;
    logic capSub;
    logic commit;
  } dpStrobe_t;

  function automatic logic loadPermitted(input logic [WORD_W-1:0] ctrlWord);
    return (ctrlWord[SIG_HI:SIG_LO] == SIG_GOOD) && ctrlWord[LOAD_BIT];
  endfunction

endpackage

// File: rtl/idload_ctrl.sv
module idload_ctrl
  import idload_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0A,
  parameter int              TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eeDone,
  output logic              eeReq,
  output logic [ADDR_W-1:0] eeAddr,
  output dpStrobe_t         strobe,
  output logic              loadDone
);

  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WORDS - 1);

  loadState_t        state, stateNext;
  logic [IDX_W-1:0]  wordIdx;
  logic [TMR_W-1:0]  waitTmr;
  logic              accept;
  logic              expired;
  logic              lastWord;

  assign accept   = (state == ST_WAIT) && eeDone;
  assign expired  = (state == ST_WAIT) && !eeDone && (waitTmr == TMR_LAST);
  assign lastWord = (wordIdx == IDX_LAST);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_START: stateNext = ST_REQ;
      ST_REQ:   stateNext = ST_WAIT;
      ST_WAIT: begin
        if (accept)       stateNext = lastWord ? ST_DONE : ST_REQ;
        else if (expired) stateNext = ST_DONE;
      end
      ST_DONE:  stateNext = ST_DONE;
      default:  stateNext = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_START;
    end else begin
      state <= stateNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wordIdx <= '0;
      eeAddr  <= BASE_ADDR;
    end else if (accept && !lastWord) begin
      wordIdx <= wordIdx + 1'b1;
      eeAddr  <= eeAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waitTmr <= '0;
    end else if (state == ST_WAIT) begin
      waitTmr <= waitTmr + 1'b1;
    end else begin
      waitTmr <= '0;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.capCtrl = accept && (wordIdx == IDX_W'(0));
    strobe.capSub  = accept && (wordIdx == IDX_W'(1));
    strobe.commit  = accept && lastWord;
  end

  assign eeReq    = (state == ST_REQ);
  assign loadDone = (state == ST_DONE);

endmodule

// File: rtl/idload_dp.sv
module idload_dp
  import idload_pkg::*;
#(
  parameter logic [4:0] REV_UPPER   = 5'b00001,
  parameter logic [7:0] REV_DEFAULT = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] eeData,
  output logic [WORD_W-1:0] subsysId,
  output logic [WORD_W-1:0] subsysVendorId,
  output logic [7:0]        revisionId
);

  logic [WORD_W-1:0] ctrlWord;
  logic [WORD_W-1:0] subWord;
  logic              permit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlWord <= '0;
      subWord  <= '0;
    end else begin
      if (strobe.capCtrl) ctrlWord <= eeData;
      if (strobe.capSub)  subWord  <= eeData;
    end
  end

  assign permit = loadPermitted(ctrlWord);

  // fields are written once, at the end, so they never show partial data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      subsysId       <= '0;
      subsysVendorId <= '0;
      revisionId     <= REV_DEFAULT;
    end else if (strobe.commit && permit) begin
      subsysId       <= subWord;
      subsysVendorId <= eeData;
      revisionId     <= {REV_UPPER, ctrlWord[REVF_HI:REVF_LO]};
    end
  end

endmodule

// File: rtl/idAutoload.sv
module idAutoload
  import idload_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h0A,
  parameter int                TIMEOUT_CYC = 1024,
  parameter logic [4:0]        REV_UPPER   = 5'b00001,
  parameter logic [7:0]        REV_DEFAULT = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              eeReq,
  output logic [ADDR_W-1:0] eeAddr,
  input  logic              eeDone,
  input  logic [15:0]       eeData,
  output logic [15:0]       subsysId,
  output logic [15:0]       subsysVendorId,
  output logic [7:0]        revisionId,
  output logic              loadDone,
  output logic              cfgRetry
);

  dpStrobe_t strobe;

  idload_ctrl #(
    .ADDR_W      (ADDR_W),
    .BASE_ADDR   (BASE_ADDR),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .eeDone   (eeDone),
    .eeReq    (eeReq),
    .eeAddr   (eeAddr),
    .strobe   (strobe),
    .loadDone (loadDone)
  );

  idload_dp #(
    .REV_UPPER   (REV_UPPER),
    .REV_DEFAULT (REV_DEFAULT)
  ) dp_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe         (strobe),
    .eeData         (eeData),
    .subsysId       (subsysId),
    .subsysVendorId (subsysVendorId),
    .revisionId     (revisionId)
  );

  assign cfgRetry = !loadDone;

endmodule

// File: rtl/idAutoload_chk.sv
module idAutoload_chk #(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h0A,
  parameter logic [4:0]        REV_UPPER   = 5'b00001,
  parameter logic [7:0]        REV_DEFAULT = 8'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eeReq,
  input logic [ADDR_W-1:0] eeAddr,
  input logic              eeDone,
  input logic [15:0]       subsysId,
  input logic [15:0]       subsysVendorId,
  input logic [7:0]        revisionId,
  input logic              loadDone
);

  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending <= 1'b0;
    else if (eeReq)  pending <= 1'b1;
    else if (eeDone) pending <= 1'b0;
  end

  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eeReq |=> !eeReq);

  p_addr_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eeReq |-> (eeAddr >= BASE_ADDR) && (eeAddr <= BASE_ADDR + ADDR_W'(2)));

  p_single_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eeReq |-> !pending);

  p_rev_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (revisionId != REV_DEFAULT) |-> (revisionId[7:3] == REV_UPPER));

  p_defaults_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !loadDone |-> (subsysId == 16'h0) && (subsysVendorId == 16'h0) &&
                  (revisionId == REV_DEFAULT));

  p_no_req_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loadDone |-> !eeReq);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loadDone |=> loadDone && $stable(subsysId) && $stable(subsysVendorId) &&
                 $stable(revisionId));

endmodule

bind idAutoload idAutoload_chk #(
  .ADDR_W      (ADDR_W),
  .BASE_ADDR   (BASE_ADDR),
  .REV_UPPER   (REV_UPPER),
  .REV_DEFAULT (REV_DEFAULT)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .eeReq          (eeReq),
  .eeAddr         (eeAddr),
  .eeDone         (eeDone),
  .subsysId       (subsysId),
  .subsysVendorId (subsysVendorId),
  .revisionId     (revisionId),
  .loadDone       (loadDone)
);

// File: tb/idAutoload_tb_top.sv
`timescale 1ns/1ps
module idAutoload_tb_top;

  localparam int         AW   = 8;
  localparam logic [7:0] BASE = 8'h0A;
  localparam int         T    = 16;
  localparam logic [4:0] RUP  = 5'b10110;
  localparam logic [7:0] RDEF = 8'h5D;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          eeReq;
  logic [AW-1:0] eeAddr;
  logic          eeDone = 1'b0;
  logic [15:0]   eeData = '0;
  logic [15:0]   subsysId, subsysVendorId;
  logic [7:0]    revisionId;
  logic          loadDone, cfgRetry;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [15:0] expSub, expVen;
  logic [7:0]  expRev;

  always #2 clk = ~clk;

  idAutoload #(
    .ADDR_W(AW), .BASE_ADDR(BASE), .TIMEOUT_CYC(T),
    .REV_UPPER(RUP), .REV_DEFAULT(RDEF)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .eeReq(eeReq), .eeAddr(eeAddr),
    .eeDone(eeDone), .eeData(eeData), .subsysId(subsysId),
    .subsysVendorId(subsysVendorId), .revisionId(revisionId),
    .loadDone(loadDone), .cfgRetry(cfgRetry)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n  = 1'b0;
    eeDone = 1'b0;
    eeData = '0;
    repeat (2) @(negedge clk);
    check("R7 reset retry", 32'(cfgRetry), 32'd1);
    check("R7 reset done", 32'(loadDone), 32'd0);
    check("R1 reset strobe", 32'(eeReq), 32'd0);
    check("R6 reset ids", {subsysId, subsysVendorId} ^ 32'(revisionId), 32'(RDEF));
    rst_n = 1'b1;
  endtask

  task automatic runLoad(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                         input int l0, input int l1, input int l2);
    logic [15:0] words [3];
    int lats [3];
    bit expTo;
    bit permit;
    words[0] = w0; words[1] = w1; words[2] = w2;
    lats[0] = l0;  lats[1] = l1;  lats[2] = l2;
    expTo  = (l0 > T) || (l1 > T) || (l2 > T);
    permit = !expTo && (w0[15:14] == 2'b01) && w0[13];
    expSub = permit ? w1 : 16'h0;
    expVen = permit ? w2 : 16'h0;
    expRev = permit ? {RUP, w0[10:8]} : RDEF;
    doReset();
    for (int i = 0; i < 3; i++) begin
      int n = 0;
      while (!eeReq && n < 40) begin @(negedge clk); n++; end
      if (!eeReq) begin
        if (!expTo) check("R1 strobe missing", 32'(eeReq), 32'd1);
        break;
      end
      check("R1 address order", 32'(eeAddr), 32'(BASE) + 32'(i));
      check("R7 retry while busy", 32'(cfgRetry), 32'd1);
      for (int c = 1; c <= lats[i]; c++) begin
        @(negedge clk);
        if (c < lats[i]) begin
          check("R2 no strobe while pending", 32'(eeReq), 32'd0);
        end else begin
          eeDone = 1'b1;
          eeData = words[i];
          check("R6 ids default mid-load", 32'(subsysId) | 32'(subsysVendorId), 32'd0);
          if (i == 2 && !expTo) check("R7 done not early", 32'(loadDone), 32'd0);
        end
      end
      @(negedge clk);
      eeDone = 1'b0;
      eeData = '0;
      if (i == 2 && !expTo) begin
        check("R7 done rises next cycle", 32'(loadDone), 32'd1);
        check("R7 retry falls", 32'(cfgRetry), 32'd0);
      end
    end
    repeat (2) @(negedge clk);
    check(expTo ? "R9 timeout ends load" : "R7 done set", 32'(loadDone), 32'd1);
    check(permit ? "R3 subsys id" : "R5 subsys id default", 32'(subsysId), 32'(expSub));
    check(permit ? "R3 vendor id" : "R5 vendor id default", 32'(subsysVendorId), 32'(expVen));
    check(permit ? "R4 revision loaded" : "R4 revision default", 32'(revisionId), 32'(expRev));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R3 R4 R5: sweep signature, enable bit and revision bits
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 2; b++) begin
        for (int r = 0; r < 8; r++) begin
          int k = s * 16 + b * 8 + r;
          logic [15:0] w0;
          w0 = {2'(s), 1'(b), 2'(k % 4), 3'(r), 8'(k * 29 + 3)};
          runLoad(w0, 16'(16'h1000 + k * 257), 16'(16'hA5C3 ^ (k * 4099)),
                  1 + (k % 3), 1 + ((k + 1) % 4), 1 + ((k + 2) % 2));
        end
      end
    end

    // R8: late completion pulse after a full load has no effect
    runLoad(16'h6500, 16'hBEEF, 16'hCAFE, 2, 1, 3);
    @(negedge clk);
    eeDone = 1'b1;
    eeData = 16'hFFFF;
    @(negedge clk);
    eeDone = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 late pulse subsys", 32'(subsysId), 32'(expSub));
    check("R8 late pulse vendor", 32'(subsysVendorId), 32'(expVen));
    check("R8 late pulse revision", 32'(revisionId), 32'(expRev));
    check("R8 no extra strobe", 32'(eeReq), 32'd0);
    check("R8 done held", 32'(loadDone), 32'd1);

    // R9: pulse in the last allowed waiting cycle wins over expiry
    runLoad(16'h7300, 16'h1234, 16'h5678, T, T, T);

    // R9: one cycle too late on each word in turn
    runLoad(16'h6700, 16'h1111, 16'h2222, T + 1, 1, 1);
    runLoad(16'h6700, 16'h3333, 16'h4444, 1, T + 1, 1);
    runLoad(16'h6700, 16'h5555, 16'h6666, 1, 1, T + 1);
    repeat (2) @(negedge clk);
    check("R9 late pulse ignored", 32'(subsysVendorId), 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule